// File: doc/BRIEF.md
# Byte-Lane Table Lookup Unit

This block performs a vector table lookup, also called a byte permute. One to four 64-bit table registers are treated as a single flat array of bytes. A 32-bit index word carries four byte-wide indices, one for each lane of a 32-bit result. Each lane picks the table byte its index addresses.

When an index falls outside the table, that lane does not produce zero. It passes through the matching byte of the old destination word instead. The table size comes in as the register count minus one, so every encoding of the size field is legal.

A caller presents the table, the size, the index word and the old destination value, then pulses a start strobe. The result is registered on that edge and shown together with a one-cycle done pulse. It holds until the next start.

Top module: `bytelut_top`

## Requirements
- R1: Result lane k (bits 8k+7:8k, k = 0..3) depends only on index byte k (index bits 8k+7:8k), table contents, size, and old destination byte k.
- R2: With size field `tbl_regs_m1_i` = n (0..3), an index i is in range exactly when i <= 8*(n+1)-1.
- R3: For an in-range index i, the lane takes byte i[2:0] of table register i[4:3]. Table register r occupies `tbl_i[64r+63:64r]`, and byte b of a register occupies bits 8b+7:8b.
- R4: For an out-of-range index, the lane takes the same lane of `old_dst_i` unchanged.
- R5: An index of 32 or more is out of range for every size setting.
- R6: `result_o` carries the looked-up word starting at the first rising edge after `start_i` is sampled high. `done_o` is high for exactly the cycle following each cycle in which `start_i` was high.
- R7: While `start_i` is low, `result_o` holds its value, whatever the other inputs do.
- R8: While reset is asserted, `result_o` is zero and `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start strobe; captures a new result on this edge |
| tbl_i | input | 256 | Table registers, register r at bits 64r+63:64r |
| tbl_regs_m1_i | input | 2 | Number of table registers minus one |
| index_i | input | 32 | Four byte indices, lane k at bits 8k+7:8k |
| old_dst_i | input | 32 | Previous destination value, kept in out-of-range lanes |
| result_o | output | 32 | Registered lookup result |
| done_o | output | 1 | One-cycle pulse when a new result is shown |

## Verification
Several checks run on every cycle: the done pulse tracks the start strobe, the result holds between starts, reset clears the outputs, and any lane whose index exceeds the table size or reaches 32 keeps the old destination byte. Only the bench scenarios can show that an in-range index selects the correct register and byte. The same goes for the exact boundary between the last valid index and the first invalid one at each of the four sizes, and for lanes behaving independently when in-range and out-of-range indices are mixed in one word.

// File: rtl/bytelut_pkg.sv
package bytelut_pkg;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned REG_W  = 64;
  localparam int unsigned BYTES_PER_REG = REG_W / LANE_W;

  // Highest valid flat byte index for a table of (regs_m1 + 1) registers.
  function automatic int unsigned last_index(input int unsigned regs_m1);
    return (regs_m1 + 1) * BYTES_PER_REG - 1;
  endfunction
endpackage

// File: rtl/bytelut_rstsync.sv
module bytelut_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/bytelut_lane.sv
module bytelut_lane #(
  parameter int unsigned LANE_W   = 8,
  parameter int unsigned REG_W    = 64,
  parameter int unsigned MAX_REGS = 4
) (
  input  logic [MAX_REGS*REG_W-1:0] tbl_i,
  input  logic [LANE_W-1:0]         idx_i,
  input  logic [LANE_W-1:0]         last_idx_i,
  input  logic [LANE_W-1:0]         old_i,
  output logic [LANE_W-1:0]         byte_o
);
  localparam int unsigned BPR    = REG_W / LANE_W;
  localparam int unsigned BSEL_W = $clog2(BPR);
  localparam int unsigned RSEL_W = (MAX_REGS > 1) ? $clog2(MAX_REGS) : 1;

  logic [BSEL_W-1:0] byte_sel;
  logic [RSEL_W-1:0] reg_sel;
  logic [REG_W-1:0]  word_sel;
  logic [LANE_W-1:0] picked;
  logic              in_range;

  assign byte_sel = idx_i[BSEL_W-1:0];
  assign reg_sel  = idx_i[BSEL_W +: RSEL_W];
  // Comparing the full index also rejects any bits above the table span.
  assign in_range = (idx_i <= last_idx_i);

  always_comb begin
    word_sel = '0;
    for (int r = 0; r < MAX_REGS; r++) begin
      if (reg_sel == RSEL_W'(r)) word_sel = tbl_i[r*REG_W +: REG_W];
    end
    picked = word_sel[byte_sel*LANE_W +: LANE_W];
  end

  assign byte_o = in_range ? picked : old_i;
endmodule

// File: rtl/bytelut_outreg.sv
module bytelut_outreg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic         done_o
);
  logic [W-1:0] q_d;
  logic         done_d;

  always_comb begin
    q_d    = en_i ? d_i : q_o;
    done_d = en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o    <= '0;
      done_o <= 1'b0;
    end else begin
      q_o    <= q_d;
      done_o <= done_d;
    end
  end

  p_done_after_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |=> done_o);
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !done_o);
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(q_o));
  p_reset_clear_r8: assert property (@(posedge clk)
    !rst_n |-> (q_o == '0 && !done_o));
endmodule

// File: rtl/bytelut_top.sv
module bytelut_top #(
  parameter int unsigned NUM_LANES = 4,
  parameter int unsigned MAX_REGS  = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  start_i,
  input  logic [MAX_REGS*bytelut_pkg::REG_W-1:0] tbl_i,
  input  logic [$clog2(MAX_REGS)-1:0]           tbl_regs_m1_i,
  input  logic [NUM_LANES*bytelut_pkg::LANE_W-1:0] index_i,
  input  logic [NUM_LANES*bytelut_pkg::LANE_W-1:0] old_dst_i,
  output logic [NUM_LANES*bytelut_pkg::LANE_W-1:0] result_o,
  output logic                                  done_o
);
  import bytelut_pkg::*;

  localparam int unsigned WORD_W   = NUM_LANES * LANE_W;
  localparam int unsigned TBL_SPAN = MAX_REGS * BYTES_PER_REG;

  logic              rst_sync_n;
  logic [LANE_W-1:0] last_idx;
  logic [WORD_W-1:0] lookup_word;

  assign last_idx = LANE_W'(last_index(32'(tbl_regs_m1_i)));

  bytelut_rstsync u_rstsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    bytelut_lane #(
      .LANE_W   (LANE_W),
      .REG_W    (REG_W),
      .MAX_REGS (MAX_REGS)
    ) u_lane (
      .tbl_i      (tbl_i),
      .idx_i      (index_i[k*LANE_W +: LANE_W]),
      .last_idx_i (last_idx),
      .old_i      (old_dst_i[k*LANE_W +: LANE_W]),
      .byte_o     (lookup_word[k*LANE_W +: LANE_W])
    );

    p_oob_keeps_old_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (start_i && index_i[k*LANE_W +: LANE_W] > last_idx)
      |=> result_o[k*LANE_W +: LANE_W] == $past(old_dst_i[k*LANE_W +: LANE_W]));

    p_past_span_oob_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (start_i && 32'(index_i[k*LANE_W +: LANE_W]) >= TBL_SPAN)
      |=> result_o[k*LANE_W +: LANE_W] == $past(old_dst_i[k*LANE_W +: LANE_W]));
  end

  bytelut_outreg #(.W(WORD_W)) u_outreg (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .en_i   (start_i),
    .d_i    (lookup_word),
    .q_o    (result_o),
    .done_o (done_o)
  );
endmodule

// File: tb/bytelut_top_tb.sv
module bytelut_top_tb;
  logic         clk;
  logic         rst_n;
  logic         start_i;
  logic [255:0] tbl_i;
  logic [1:0]   tbl_regs_m1_i;
  logic [31:0]  index_i;
  logic [31:0]  old_dst_i;
  logic [31:0]  result_o;
  logic         done_o;

  int vec_count;
  int err_count;
  bit finished;

  bytelut_top u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .tbl_i         (tbl_i),
    .tbl_regs_m1_i (tbl_regs_m1_i),
    .index_i       (index_i),
    .old_dst_i     (old_dst_i),
    .result_o      (result_o),
    .done_o        (done_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Reference: R1 lanes, R2 range, R3 selection, R4/R5 old byte kept.
  function automatic logic [31:0] model(input logic [255:0] t, input logic [1:0] n,
                                        input logic [31:0] ix, input logic [31:0] pv);
    logic [31:0] r;
    for (int k = 0; k < 4; k++) begin
      int unsigned b;
      b = ix[k*8 +: 8];
      if (b <= 8 * (int'(n) + 1) - 1)
        r[k*8 +: 8] = t[(b / 8) * 64 + (b % 8) * 8 +: 8];
      else
        r[k*8 +: 8] = pv[k*8 +: 8];
    end
    return r;
  endfunction

  function automatic logic [255:0] rand_table();
    logic [255:0] t;
    for (int w = 0; w < 8; w++) t[w*32 +: 32] = $urandom;
    return t;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    vec_count++;
    if (!ok) begin
      err_count++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_vec(input logic [255:0] t, input logic [1:0] n,
                         input logic [31:0] ix, input logic [31:0] pv, input string req);
    logic [31:0] exp;
    exp = model(t, n, ix, pv);
    tbl_i = t; tbl_regs_m1_i = n; index_i = ix; old_dst_i = pv;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(result_o == exp, req, result_o, exp);
    check(done_o == 1'b1, "R6 done high", {31'd0, done_o}, 32'd1);
    index_i = ~ix; old_dst_i = ~pv; tbl_i = ~t;
    @(negedge clk);
    check(done_o == 1'b0, "R6 done single cycle", {31'd0, done_o}, 32'd0);
    check(result_o == exp, "R7 hold while idle", result_o, exp);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vec_count, err_count);
      $finish;
    end
  endtask

  initial begin
    #800000;
    err_count++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [255:0] t;
    logic [31:0]  ix;
    vec_count = 0; err_count = 0; finished = 1'b0;
    void'($urandom(32'd2718));
    rst_n = 1'b1; start_i = 1'b0;
    tbl_i = '0; tbl_regs_m1_i = '0; index_i = '0; old_dst_i = '0;
    #1 rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    check(result_o == 32'd0, "R8 reset result", result_o, 32'd0);
    check(done_o == 1'b0, "R8 reset done", {31'd0, done_o}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3: known table, byte value encodes its flat position.
    for (int i = 0; i < 32; i++) t[i*8 +: 8] = 8'(8'hA0 + i);
    run_vec(t, 2'd3, 32'h1F_10_08_00, 32'hDEADBEEF, "R3 register/byte select");
    run_vec(t, 2'd3, 32'h07_0F_17_1F, 32'h01234567, "R3 top bytes");
    // R2 boundaries per size: last valid and first invalid index.
    for (int n = 0; n < 4; n++) begin
      logic [7:0] lastv;
      lastv = 8'(8 * (n + 1) - 1);
      run_vec(t, 2'(n), {lastv, 8'(lastv + 1), lastv, 8'(lastv + 1)}, 32'hCAFEF00D,
              "R2 boundary");
    end
    // R5: 32 and above out of range at full size.
    run_vec(t, 2'd3, 32'h20_FF_80_21, 32'h5A5AA5A5, "R5 high index");
    // R4/R1: mixed lanes, only out-of-range ones keep old bytes.
    run_vec(t, 2'd0, 32'h03_09_00_40, 32'h11223344, "R4 R1 mixed lanes");

    for (int v = 0; v < 300; v++) begin
      t = rand_table();
      for (int k = 0; k < 4; k++)
        ix[k*8 +: 8] = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 33);
      run_vec(t, 2'($urandom), ix, $urandom, "R1 R3 R4 random");
      if ($urandom % 3 == 0) @(negedge clk);
    end

    finish_run();
  end
endmodule